// File: doc/BRIEF.md
# Flash End-of-Write Status Generator

This block forms the word a flash bank returns on a read while the bank runs an internal program or erase. A one-cycle start strobe begins an operation. For a program, the strobe also captures the word being written. An internal cycle counter then holds the bank busy for a time set by a parameter, and the count depends on the kind of operation.

While the bank is busy, two bits of every read word carry progress information instead of stored data. Bit 7 is a polarity flag. Bit 6 inverts on each successive read. Every other bit, and the whole word when the bank is idle, passes straight through from the array.

Software polls these two bits to detect completion. The block raises a one-cycle done pulse when the counter expires.

Top module: `flashStatusGen`

## Requirements
- R1: After reset the block is idle. `busy` and `donePulse` are 0, the read word equals `arrayWord`, and the first busy read returns 0 on bit 6.
- R2: A `startProg` sampled while idle makes `busy` read 1 from the next cycle, for exactly PROG_CYC cycles.
- R3: A `startErase` sampled while idle keeps `busy` at 1 for a number of cycles set by `eraseKind`. Code 0 gives SECT_CYC cycles, code 1 gives BLK_CYC cycles, and codes 2 and 3 give CHIP_CYC cycles.
- R4: While a program is busy, bit 7 of the read word is the inverse of bit 7 of the captured `progWord`.
- R5: While an erase is busy, bit 7 of the read word is 0, whatever the array holds.
- R6: While busy, bit 6 of the read word is a toggle value. It inverts after every cycle in which `rdStrobe` is 1 and is unchanged after cycles without a read.
- R7: While busy, bits 15..8 and 5..0 of the read word equal the same bits of `arrayWord`.
- R8: While idle, the read word equals `arrayWord` on all 16 bits.
- R9: The toggle value is held while idle, so the first read of the next operation continues from the last value.
- R10: `donePulse` is 1 for exactly one cycle. That cycle is the first one in which `busy` reads 0 after an operation.
- R11: Start strobes sampled while busy are ignored. They extend nothing, and they change neither the captured word nor the kind of operation.
- R12: If both start strobes are sampled together while idle, the program wins. It runs for PROG_CYC cycles and reports program polarity on bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startProg | input | 1 | One-cycle request to begin an internal program |
| startErase | input | 1 | One-cycle request to begin an internal erase |
| eraseKind | input | 2 | Erase size: 0 sector, 1 block, 2 or 3 whole chip |
| progWord | input | 16 | Word being programmed, captured with `startProg` |
| rdStrobe | input | 1 | A flash read occurs in this cycle |
| arrayWord | input | 16 | Word stored at the read address |
| rdWord | output | 16 | Word returned to the reader |
| busy | output | 1 | Internal operation in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
Directed runs cover the following cases:
- A program with captured bit 7 set to 1, and one with it set to 0, which separates true polarity from complemented polarity.
- An erase of each size over an array word whose bit 7 is 1, which shows that bit 7 is forced to 0 rather than passed through.
- Reads on consecutive cycles, and reads with gaps between them, which separate per-read toggling from per-cycle toggling.
- Start strobes issued while busy, and both strobes issued in one cycle, which expose faults in duration and priority.

A long stretch of random strobes and array words is checked cycle by cycle against a bench model. This stretch catches any mixing of status bits into the pass-through lanes.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [1:0] {
    ERS_SECTOR = 2'd0,
    ERS_BLOCK  = 2'd1,
    ERS_CHIP   = 2'd2,
    ERS_CHIP2  = 2'd3
  } eraseKind_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // operation accepted this cycle
    logic isProg;   // accepted operation is a program
    logic active;   // operation in progress
    logic flip;     // invert the toggle value at this edge
  } stb_t;

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import fsg_pkg::*;
#(
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 2500000,
  parameter int BLK_CYC  = 2500000,
  parameter int CHIP_CYC = 10000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startProg,
  input  logic       startErase,
  input  logic [1:0] eraseKind,
  input  logic       rdStrobe,
  output stb_t       stb,
  output logic       busy,
  output logic       donePulse
);

  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] loadLen;
  logic          busyQ;
  logic          doneQ;
  logic          accept;
  logic          lastCycle;

  assign accept    = !busyQ && (startProg || startErase);
  assign lastCycle = busyQ && (cnt == '0);

  always_comb begin
    if (startProg) begin
      loadLen = CW'(PROG_CYC - 1);
    end else begin
      case (eraseKind_e'(eraseKind))
        ERS_SECTOR: loadLen = CW'(SECT_CYC - 1);
        ERS_BLOCK:  loadLen = CW'(BLK_CYC - 1);
        default:    loadLen = CW'(CHIP_CYC - 1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      cnt   <= '0;
    end else begin
      doneQ <= lastCycle;
      if (busyQ) begin
        if (cnt == '0) busyQ <= 1'b0;
        else           cnt   <= cnt - 1'b1;
      end else if (accept) begin
        busyQ <= 1'b1;
        cnt   <= loadLen;
      end
    end
  end

  assign stb.capture = accept;
  assign stb.isProg  = startProg;
  assign stb.active  = busyQ;
  assign stb.flip    = busyQ && rdStrobe;
  assign busy        = busyQ;
  assign donePulse   = doneQ;

  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (!busy && $past(busy)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  a_r11_no_early_end: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> busy);
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startProg) |=> busy);

endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int POL_BIT = 7,
  parameter int TOG_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  stb_t              stb,
  input  logic [WORD_W-1:0] progWord,
  input  logic [WORD_W-1:0] arrayWord,
  output logic [WORD_W-1:0] rdWord
);

  logic [WORD_W-1:0] wordQ;
  logic              progQ;
  logic              togQ;
  logic              polBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      progQ <= 1'b0;
      togQ  <= 1'b0;
    end else begin
      if (stb.capture) begin
        wordQ <= progWord;
        progQ <= stb.isProg;
      end
      if (stb.flip) togQ <= ~togQ;
    end
  end

  // Program: inverted captured bit; erase: forced low
  assign polBit = progQ ? ~wordQ[POL_BIT] : 1'b0;

  for (genvar i = 0; i < WORD_W; i++) begin : g_lane
    if (i == POL_BIT) begin : g_pol
      assign rdWord[i] = stb.active ? polBit : arrayWord[i];
    end else if (i == TOG_BIT) begin : g_tog
      assign rdWord[i] = stb.active ? togQ : arrayWord[i];
    end else begin : g_pass
      assign rdWord[i] = arrayWord[i];
    end
  end

  a_r9_toggle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |=> $stable(togQ));
  a_r11_word_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.active |=> ($stable(wordQ) && $stable(progQ)));

endmodule

// File: rtl/flashStatusGen.sv
module flashStatusGen #(
  parameter int PROG_CYC = 2000,
  parameter int SECT_CYC = 2500000,
  parameter int BLK_CYC  = 2500000,
  parameter int CHIP_CYC = 10000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startProg,
  input  logic        startErase,
  input  logic [1:0]  eraseKind,
  input  logic [15:0] progWord,
  input  logic        rdStrobe,
  input  logic [15:0] arrayWord,
  output logic [15:0] rdWord,
  output logic        busy,
  output logic        donePulse
);

  fsg_pkg::stb_t stb;

  fsg_ctrl #(
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC),
    .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startProg(startProg), .startErase(startErase),
    .eraseKind(eraseKind), .rdStrobe(rdStrobe), .stb(stb),
    .busy(busy), .donePulse(donePulse)
  );

  fsg_datapath #(.WORD_W(16), .POL_BIT(7), .TOG_BIT(6)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .progWord(progWord),
    .arrayWord(arrayWord), .rdWord(rdWord)
  );

endmodule

// File: tb/flashStatusGen_bench.sv
module flashStatusGen_bench;

  localparam int P = 5, S = 7, B = 9, C = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startProg = 1'b0, startErase = 1'b0, rdStrobe = 1'b0;
  logic [1:0]  eraseKind = 2'd0;
  logic [15:0] progWord = '0, arrayWord = '0;
  logic [15:0] rdWord;
  logic        busy, donePulse;

  int nChk = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  // bench model state
  bit busyM = 0, doneM = 0, progM = 0, togM = 0;
  logic [15:0] wordM = '0;
  int cntM = 0;

  always #5 clk = ~clk;

  flashStatusGen #(.PROG_CYC(P), .SECT_CYC(S), .BLK_CYC(B), .CHIP_CYC(C)) u_flashStatusGen (
    .clk(clk), .rstN(rstN), .startProg(startProg), .startErase(startErase),
    .eraseKind(eraseKind), .progWord(progWord), .rdStrobe(rdStrobe),
    .arrayWord(arrayWord), .rdWord(rdWord), .busy(busy), .donePulse(donePulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int eraseLen(input logic [1:0] k);
    case (k)
      2'd0: return S;
      2'd1: return B;
      default: return C;
    endcase
  endfunction

  function automatic logic [15:0] expWord(input logic [15:0] arr);
    logic [15:0] w;
    w = arr;
    if (busyM) begin
      w[7] = progM ? ~wordM[7] : 1'b0;
      w[6] = togM;
    end
    return w;
  endfunction

  // Drive one cycle of inputs, compare at mid-cycle, advance the model at the edge.
  task automatic tick(input bit sp, input bit se, input logic [1:0] k,
                      input logic [15:0] w, input bit rd, input logic [15:0] arr);
    logic [15:0] e;
    startProg = sp; startErase = se; eraseKind = k; progWord = w;
    rdStrobe = rd; arrayWord = arr;
    #1;
    e = expWord(arr);
    chk(busy == busyM, "R2/R3 busy", 32'(busy), 32'(busyM));
    chk(donePulse == doneM, "R10 donePulse", 32'(donePulse), 32'(doneM));
    chk(rdWord[7] == e[7], busyM ? (progM ? "R4 bit7" : "R5 bit7") : "R8 bit7",
        32'(rdWord[7]), 32'(e[7]));
    chk(rdWord[6] == e[6], busyM ? "R6 bit6" : "R8 bit6", 32'(rdWord[6]), 32'(e[6]));
    chk({rdWord[15:8], rdWord[5:0]} == {e[15:8], e[5:0]}, busyM ? "R7 lanes" : "R8 lanes",
        32'(rdWord), 32'(e));
    @(posedge clk);
    doneM = busyM && (cntM == 0);
    if (busyM) begin
      if (rd) togM = ~togM;
      if (cntM == 0) busyM = 0; else cntM--;
    end else if (sp) begin
      busyM = 1; progM = 1; wordM = w; cntM = P - 1;
    end else if (se) begin
      busyM = 1; progM = 0; cntM = eraseLen(k) - 1;
    end
    @(negedge clk);
  endtask

  task automatic drain(output int n, input bit rd);
    n = 0;
    while (busyM && n < 100) begin
      if (busy) n++;
      tick(0, 0, 2'd0, 16'h0, rd, 16'hFFFF);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    bit t0;
    void'($urandom(32'h5EED));
    arrayWord = 16'hA5C3;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(busy == 0 && donePulse == 0, "R1 reset flags", {busy, donePulse}, 0);
    chk(rdWord == arrayWord, "R1 reset passthrough", rdWord, arrayWord);
    @(negedge clk);
    rstN = 1;

    // R1/R2/R4: program with captured bit7 = 1, first read bit6 = 0
    tick(1, 0, 0, 16'h0080, 0, 16'h1234);
    #1 chk(rdWord[7] == 0 && rdWord[6] == 0, "R1 R4 first poll", rdWord[7:6], 2'b00);
    drain(n, 1);
    chk(n == P, "R2 program length", n, P);
    // R4 with captured bit7 = 0
    tick(1, 0, 0, 16'h7F00, 0, 16'h0000);
    #1 chk(rdWord[7] == 1, "R4 inverted zero", rdWord[7], 1);
    drain(n, 0);
    chk(n == P, "R2 program length no reads", n, P);

    // R3/R5 each erase size, array bit7 = 1
    for (int k = 0; k < 4; k++) begin
      tick(0, 1, 2'(k), 16'h0, 0, 16'hFFFF);
      #1 chk(rdWord[7] == 0, "R5 erase bit7", rdWord[7], 0);
      drain(n, 1);
      chk(n == eraseLen(2'(k)), "R3 erase length", n, eraseLen(2'(k)));
    end

    // R9 toggle held across idle gap
    t0 = togM;
    repeat (4) tick(0, 0, 0, 0, 1, 16'h00FF);
    tick(0, 1, 0, 0, 1, 16'h0000);
    #1 chk(rdWord[6] == t0, "R9 toggle held", rdWord[6], t0);
    drain(n, 1);

    // R11 strobes while busy ignored
    tick(1, 0, 0, 16'h0000, 1, 16'h0);
    tick(0, 1, 2'd2, 16'h0, 1, 16'h0);
    tick(1, 0, 0, 16'h0080, 1, 16'h0);
    #1 chk(rdWord[7] == 1, "R11 word kept", rdWord[7], 1);
    drain(n, 1);
    chk(n == P - 2, "R11 length unchanged", n, P - 2);

    // R12 both strobes: program wins
    tick(1, 1, 2'd2, 16'h0000, 0, 16'h0);
    #1 chk(rdWord[7] == 1, "R12 program polarity", rdWord[7], 1);
    drain(n, 1);
    chk(n == P, "R12 program length", n, P);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      tick(($urandom % 8) == 0, ($urandom % 10) == 0, 2'($urandom),
           16'($urandom), $urandom % 2, 16'($urandom));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule